// File: doc/BRIEF.md
# T1-to-highway time slot mapper

This block adapts a 24-channel T1 frame to a 32-slot serial highway frame. For every highway slot it works out whether the slot is one of the eight stuffed idle slots. If it is not, it works out which T1 channel the slot carries. A single mapping serves both directions: the receive side uses the slot/channel relation to steer incoming bytes, and the transmit side uses it to choose the byte to send.

There are two ways to place the idle slots. In distributed mode, one slot in every group of four is idle, and the phase of that slot within the group is selectable. In grouped mode, all eight idle slots sit at the tail of the frame. The transmit path registers one byte per slot. That byte is the caller's channel byte, or the programmable idle code when the slot is idle. A per-slot disable mask drops the output enable so that a tri-state driver outside the block releases the highway for that slot.

An external slot counter drives the block and advances by one slot per clock. The active placement is reloaded only at the frame boundary, so a mode write never splits a frame between two mappings.

Top module: `t1_slot_mapper`

## Requirements
- R1: Every 32-slot frame holds exactly 24 non-idle slots and 8 idle slots, whatever the placement.
- R2: With an active mode value of 0 to 3, slot s is idle exactly when s mod 4 equals the mode value.
- R3: With an active mode value of 4 to 7, slots 24 to 31 are idle and slots 0 to 23 are not.
- R4: Non-idle slots report channel indices 0 to 23 in increasing slot order with no gap. In distributed mode with phase p, the channel is 3*(s div 4) + (s mod 4), minus one when s mod 4 exceeds p. In grouped mode the channel is s. An idle slot reports channel 0.
- R5: One clock after a slot is presented, the output byte holds the idle code if that slot was idle, and the channel byte input otherwise.
- R6: When bit s of the disable mask is 1 while slot s is presented, the output enable is 0 in the following cycle. Otherwise it is 1.
- R7: The mode input is captured only on the clock where the slot index is 31, so a new placement applies from slot 0 of the next frame. A change in the middle of a frame has no effect on that frame.
- R8: While reset is held, the output byte is 0 and the output enable is 0. After reset, the active placement is distributed with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_idx | input | 5 | Current highway slot number |
| mode_cfg | input | 3 | Requested idle placement (0-3 distributed phase, 4-7 grouped) |
| idle_code | input | 8 | Byte sent in idle slots |
| slot_off | input | 32 | Per-slot disable mask, bit s for slot s |
| chan_byte | input | 8 | Byte of the channel named by chan_idx |
| slot_idle | output | 1 | Current slot is an idle slot |
| chan_idx | output | 5 | T1 channel carried by the current slot |
| hw_byte | output | 8 | Registered highway byte for the previous slot |
| hw_oe | output | 1 | Registered output enable for the previous slot |

## Verification
The assertions assume that the slot index advances by exactly one each clock and wraps from 31 to 0, because the frame-boundary stability check only holds for a counter that behaves this way. They also assume that chan_byte and idle_code are steady for the whole of each cycle. The bench never jumps the counter. It sweeps every slot of every frame in one continuous count, and it changes mode_cfg, the mask and the idle code only between edges, some of these changes falling in the middle of a frame.

// File: rtl/t1_slot_mapper.sv
module t1_slot_mapper #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        slot_idx,
  input  logic [2:0]        mode_cfg,
  input  logic [BYTE_W-1:0] idle_code,
  input  logic [31:0]       slot_off,
  input  logic [BYTE_W-1:0] chan_byte,
  output logic              slot_idle,
  output logic [4:0]        chan_idx,
  output logic [BYTE_W-1:0] hw_byte,
  output logic              hw_oe
);
  localparam logic [4:0] LAST_SLOT = 5'd31;
  localparam logic [4:0] TAIL_START = 5'd24;

  logic [2:0] mode_q;
  logic [4:0] dist_ch;

  wire       grouped = mode_q[2];
  wire [1:0] phase   = mode_q[1:0];
  wire [1:0] pos     = slot_idx[1:0];
  wire [2:0] grp     = slot_idx[4:2];

  assign slot_idle = grouped ? (slot_idx >= TAIL_START) : (pos == phase);

  always_comb begin
    dist_ch = 5'(grp) * 5'd3 + 5'(pos);
    if (pos > phase) dist_ch = dist_ch - 5'd1;
  end

  assign chan_idx = slot_idle ? 5'd0 : (grouped ? slot_idx : dist_ch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      hw_byte <= '0;
      hw_oe   <= 1'b0;
    end else begin
      if (slot_idx == LAST_SLOT) mode_q <= mode_cfg;
      hw_byte <= slot_idle ? idle_code : chan_byte;
      hw_oe   <= ~slot_off[slot_idx];
    end
  end
endmodule

module t1_slot_mapper_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        slot_idx,
  input logic [BYTE_W-1:0] idle_code,
  input logic [31:0]       slot_off,
  input logic [BYTE_W-1:0] chan_byte,
  input logic              slot_idle,
  input logic [4:0]        chan_idx,
  input logic [BYTE_W-1:0] hw_byte,
  input logic              hw_oe,
  input logic [2:0]        mode_q
);
  a_r4_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_idle |-> chan_idx < 5'd24);

  a_r4_idle_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idle |-> chan_idx == 5'd0);

  a_r5_idle_byte: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idle |=> hw_byte == $past(idle_code));

  a_r5_data_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_idle |=> hw_byte == $past(chan_byte));

  a_r6_slot_disable: assert property (@(posedge clk) disable iff (!rst_n)
    slot_off[slot_idx] |=> !hw_oe);

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx != 5'd0 |-> $stable(mode_q));
endmodule

bind t1_slot_mapper t1_slot_mapper_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .idle_code(idle_code),
  .slot_off(slot_off), .chan_byte(chan_byte), .slot_idle(slot_idle),
  .chan_idx(chan_idx), .hw_byte(hw_byte), .hw_oe(hw_oe), .mode_q(mode_q)
);

// File: tb/sim_t1_slot_mapper.sv
`timescale 1ns/1ps
module sim_t1_slot_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  slot_idx = '0;
  logic [2:0]  mode_cfg = '0;
  logic [7:0]  idle_code = 8'h7F;
  logic [31:0] slot_off = '0;
  logic [7:0]  chan_byte = '0;
  logic        slot_idle;
  logic [4:0]  chan_idx;
  logic [7:0]  hw_byte;
  logic        hw_oe;

  int checks = 0;
  int fails = 0;
  int act_mode = 0;
  bit p_valid = 0;
  bit p_off = 0;
  logic [7:0] p_byte = '0;

  always #4 clk = ~clk;

  t1_slot_mapper u0 (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .mode_cfg(mode_cfg),
    .idle_code(idle_code), .slot_off(slot_off), .chan_byte(chan_byte),
    .slot_idle(slot_idle), .chan_idx(chan_idx), .hw_byte(hw_byte), .hw_oe(hw_oe)
  );

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic bit exp_idle(int m, int s);
    if (m >= 4) return s >= 24;
    return (s % 4) == m;
  endfunction

  function automatic int exp_chan(int m, int s);
    if (exp_idle(m, s)) return 0;
    if (m >= 4) return s;
    return 3 * (s / 4) + (s % 4) - (((s % 4) > m) ? 1 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pending();
    if (p_valid) begin
      chk("R6 output enable", int'(hw_oe), p_off ? 0 : 1);
      chk("R5 output byte", int'(hw_byte), int'(p_byte));
    end
  endtask

  task automatic run_frame(input logic [2:0] next_cfg, input int chg_slot,
                           input logic [31:0] mask, input logic [7:0] code);
    int n_idle = 0;
    int next_ch = 0;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      check_pending();
      slot_idx  = 5'(s);
      slot_off  = mask;
      idle_code = code;
      if (s == chg_slot) mode_cfg = next_cfg;
      chan_byte = 8'((s * 37 + act_mode * 5 + 11) ^ 8'hA5);
      #1;
      if (act_mode >= 4) chk("R3 grouped idle", int'(slot_idle), int'(exp_idle(act_mode, s)));
      else chk("R2 distributed idle", int'(slot_idle), int'(exp_idle(act_mode, s)));
      chk("R4 channel index", int'(chan_idx), exp_chan(act_mode, s));
      if (!exp_idle(act_mode, s)) begin
        chk("R4 no gap in channels", int'(chan_idx), next_ch);
        next_ch++;
      end else n_idle++;
      p_valid = 1;
      p_off   = mask[s];
      p_byte  = exp_idle(act_mode, s) ? code : chan_byte;
    end
    chk("R1 idle slots per frame", n_idle, 8);
    chk("R1 channel slots per frame", next_ch, 24);
    act_mode = int'(mode_cfg);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset byte", int'(hw_byte), 0);
    chk("R8 reset enable", int'(hw_oe), 0);
    rst_n = 1'b1;
    run_frame(3'd1, 0, 32'h0, 8'h7F);
    run_frame(3'd2, 5, 32'h8000_0001, 8'h55);
    run_frame(3'd3, 31, 32'h0000_F00F, 8'hD5);
    run_frame(3'd4, 12, 32'hAAAA_AAAA, 8'hFF);
    run_frame(3'd5, 20, 32'h0, 8'h00);
    run_frame(3'd7, 3, 32'hFF00_0000, 8'h13);
    run_frame(3'd0, 16, 32'hFFFF_FFFF, 8'h7E);
    run_frame(3'd6, 30, 32'h1248_8421, 8'hC3);
    run_frame(3'd2, 1, 32'h0, 8'h81);
    run_frame(3'd2, 0, 32'h0, 8'h42);
    @(negedge clk);
    check_pending();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule